// File: doc/BRIEF.md
# Thermal Core-Migration Controller

This controller supervises a group of identical high-performance cores, of which exactly one runs at any moment while the rest stay power-gated. Every cycle it samples a temperature reading from each core and one ambient reading. When the running core becomes too hot, the controller hands execution to the coolest gated core. Repeated handovers spread heat evenly across the whole group, and on-chip readings rather than a fixed timer set how often they happen.

The hot limit is a base threshold lowered by a scaled ambient term. A cool environment therefore tolerates a higher core temperature, and migrations happen less often. A handover powers the destination core up first and waits a programmable power-good delay. It then raises a migrate request to the context-transfer logic and holds it until that logic signals completion. Only after completion does it gate the old core. A minimum dwell time separates successive migrations.

Top module: `thermal_migrator`

## Requirements
- R1: After synchronous reset, only core 0 is powered (`core_pwr_en` = 1), `migrate_req` is 0 and `active_idx` is 0.
- R2: While no handover is in progress, exactly one bit of `core_pwr_en` is set, and it is the bit of `active_idx`. At no time are more than two bits set.
- R3: Core temperatures and the ambient reading are registered once before use. The effective threshold is `base_thresh - (ambient_temp >> AMB_SHIFT)`, clamped at 0. A migration starts when the sampled temperature of the active core is greater than or equal to this threshold. Below it, no migration starts.
- R4: A lower ambient reading raises the effective threshold, so the same core temperature that triggers a migration under warm ambient triggers none under cool ambient.
- R5: The destination is the gated core with the lowest sampled temperature. On a tie, the lowest index wins. The destination never equals the active core.
- R6: While the active core stays hot, a migration starts exactly `min_dwell`+1 cycles after the previous handover completes. It never starts earlier.
- R7: `migrate_req` rises `pgood_delay`+1 cycles after the destination's bit of `core_pwr_en` is set. During that whole window both the old and the new core are powered.
- R8: `migrate_req` stays high until `xfer_done` is sampled high, and it falls on the following clock edge.
- R9: One cycle after `migrate_req` falls, the old core is gated, `core_pwr_en` holds only the destination bit, and `active_idx` equals `target_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_temp | input | N_CORES*TEMP_W | Per-core temperature, core i at bits [i*TEMP_W +: TEMP_W] |
| ambient_temp | input | TEMP_W | Ambient temperature reading |
| base_thresh | input | TEMP_W | Hot limit before ambient adjustment |
| min_dwell | input | DWELL_W | Minimum cycles between handover completion and the next trigger |
| pgood_delay | input | PGOOD_W | Power-good wait, in cycles |
| xfer_done | input | 1 | Context transfer completed |
| core_pwr_en | output | N_CORES | Per-core power enable |
| migrate_req | output | 1 | Request to move context to `target_idx` |
| target_idx | output | IDX_W | Destination core of the current or last handover |
| active_idx | output | IDX_W | Core currently owning execution |

## Verification
On every cycle, the assertions check the power invariants: a single powered core outside a handover, never more than two powered cores, and power always present on the active core. They also check that the request is held until the transfer completes, that it drops on the next edge, that gating follows one cycle later, and that the destination differs from the active core. The timing and choice rules need the bench scenarios. These cover the inclusive threshold comparison and its dependence on ambient, coolest-core selection with ties, the exact dwell and power-good intervals, and the full sequence of three chained handovers.

// File: rtl/tmig_pkg.sv
package tmig_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PWRUP = 2'd1,
    ST_XFER  = 2'd2,
    ST_GATE  = 2'd3
  } tmig_state_e;
endpackage

// File: rtl/tmig_sample.sv
// Input register stage for temperature readings.
module tmig_sample #(
  parameter int N  = 4,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N*TW-1:0] temps_in,
  input  logic [TW-1:0] amb_in,
  output logic [N*TW-1:0] temps_q,
  output logic [TW-1:0] amb_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      temps_q <= '0;
      amb_q   <= '0;
    end else begin
      temps_q <= temps_in;
      amb_q   <= amb_in;
    end
  end
endmodule

// File: rtl/tmig_thresh.sv
// Effective hot limit: base lowered by a scaled ambient term, clamped at zero.
module tmig_thresh #(
  parameter int TW = 8,
  parameter int SH = 2
) (
  input  logic [TW-1:0] base,
  input  logic [TW-1:0] amb_q,
  output logic [TW-1:0] thresh
);
  logic [TW-1:0] amb_term;
  assign amb_term = amb_q >> SH;
  assign thresh   = (base > amb_term) ? (base - amb_term) : '0;
endmodule

// File: rtl/tmig_select.sv
// Picks the coolest unpowered core; strict compare keeps the lowest index on ties.
module tmig_select #(
  parameter int N  = 4,
  parameter int TW = 8,
  parameter int IW = 2
) (
  input  logic [N*TW-1:0] temps_q,
  input  logic [N-1:0]    pwr_en,
  output logic [IW-1:0]   cand_idx
);
  logic [TW-1:0] t_arr [N];

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_unpack
      assign t_arr[g] = temps_q[g*TW +: TW];
    end
  endgenerate

  logic          found;
  logic [TW-1:0] best_t;

  always_comb begin
    found    = 1'b0;
    best_t   = '1;
    cand_idx = '0;
    for (int i = 0; i < N; i++) begin
      if (!pwr_en[i] && (!found || (t_arr[i] < best_t))) begin
        found    = 1'b1;
        best_t   = t_arr[i];
        cand_idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/tmig_fsm.sv
// Handover sequencer: trigger, power-up wait, transfer handshake, gating.
module tmig_fsm
  import tmig_pkg::*;
#(
  parameter int N  = 4,
  parameter int TW = 8,
  parameter int DW = 16,
  parameter int PW = 8,
  parameter int IW = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N*TW-1:0] temps_q,
  input  logic [TW-1:0]   thresh,
  input  logic [IW-1:0]   cand_idx,
  input  logic [DW-1:0]   min_dwell,
  input  logic [PW-1:0]   pgood_delay,
  input  logic            xfer_done,
  output logic [N-1:0]    pwr_en,
  output logic            migrate_req,
  output logic [IW-1:0]   target_idx,
  output logic [IW-1:0]   active_idx
);
  localparam logic [N-1:0] RESET_PWR = N'(1);

  tmig_state_e   state;
  logic [DW-1:0] dwell_cnt;
  logic [PW-1:0] pg_cnt;
  logic [TW-1:0] act_temp;
  logic          hot;
  logic          dwell_ok;

  assign act_temp = temps_q[active_idx*TW +: TW];
  assign hot      = (act_temp >= thresh);
  assign dwell_ok = (dwell_cnt >= min_dwell);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      pwr_en      <= RESET_PWR;
      migrate_req <= 1'b0;
      target_idx  <= '0;
      active_idx  <= '0;
      dwell_cnt   <= '0;
      pg_cnt      <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (hot && dwell_ok) begin
            target_idx       <= cand_idx;
            pwr_en[cand_idx] <= 1'b1;
            pg_cnt           <= '0;
            state            <= ST_PWRUP;
          end else if (dwell_cnt != '1) begin
            dwell_cnt <= dwell_cnt + 1'b1;
          end
        end
        ST_PWRUP: begin
          if (pg_cnt == pgood_delay) begin
            migrate_req <= 1'b1;
            state       <= ST_XFER;
          end else begin
            pg_cnt <= pg_cnt + 1'b1;
          end
        end
        ST_XFER: begin
          if (xfer_done) begin
            migrate_req <= 1'b0;
            state       <= ST_GATE;
          end
        end
        ST_GATE: begin
          pwr_en[active_idx] <= 1'b0;
          active_idx         <= target_idx;
          dwell_cnt          <= '0;
          state              <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: a single powered core whenever no handover is running
  p_single_core_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> ($countones(pwr_en) == 1));

  // R2: the handover window never powers more than two cores
  p_max_two_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(pwr_en) <= 2);

  // R2: the active core is never unpowered
  p_active_powered_r2: assert property (@(posedge clk) disable iff (rst)
    pwr_en[active_idx]);

  // R5: destination differs from the active core during a handover
  p_target_differs_r5: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> (target_idx != active_idx));

  // R8: request held while transfer not done
  p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (migrate_req && !xfer_done) |=> migrate_req);

  // R8: request dropped right after done
  p_req_drop_r8: assert property (@(posedge clk) disable iff (rst)
    (migrate_req && xfer_done) |=> !migrate_req);

  // R9: old core gated and active updated one cycle after request falls
  p_gate_after_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(migrate_req) |=> ((pwr_en == (RESET_PWR << target_idx)) && (active_idx == target_idx)));
endmodule

// File: rtl/thermal_migrator.sv
module thermal_migrator #(
  parameter int N_CORES   = 4,
  parameter int TEMP_W    = 8,
  parameter int DWELL_W   = 16,
  parameter int PGOOD_W   = 8,
  parameter int AMB_SHIFT = 2,
  parameter int IDX_W     = (N_CORES > 1) ? $clog2(N_CORES) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [N_CORES*TEMP_W-1:0] core_temp,
  input  logic [TEMP_W-1:0]         ambient_temp,
  input  logic [TEMP_W-1:0]         base_thresh,
  input  logic [DWELL_W-1:0]        min_dwell,
  input  logic [PGOOD_W-1:0]        pgood_delay,
  input  logic                      xfer_done,
  output logic [N_CORES-1:0]        core_pwr_en,
  output logic                      migrate_req,
  output logic [IDX_W-1:0]          target_idx,
  output logic [IDX_W-1:0]          active_idx
);
  logic [N_CORES*TEMP_W-1:0] temps_q;
  logic [TEMP_W-1:0]         amb_q;
  logic [TEMP_W-1:0]         thresh;
  logic [IDX_W-1:0]          cand_idx;

  tmig_sample #(.N(N_CORES), .TW(TEMP_W)) i_sample (
    .clk      (clk),
    .rst      (rst),
    .temps_in (core_temp),
    .amb_in   (ambient_temp),
    .temps_q  (temps_q),
    .amb_q    (amb_q)
  );

  tmig_thresh #(.TW(TEMP_W), .SH(AMB_SHIFT)) i_thresh (
    .base   (base_thresh),
    .amb_q  (amb_q),
    .thresh (thresh)
  );

  tmig_select #(.N(N_CORES), .TW(TEMP_W), .IW(IDX_W)) i_select (
    .temps_q  (temps_q),
    .pwr_en   (core_pwr_en),
    .cand_idx (cand_idx)
  );

  tmig_fsm #(
    .N(N_CORES), .TW(TEMP_W), .DW(DWELL_W), .PW(PGOOD_W), .IW(IDX_W)
  ) i_fsm (
    .clk         (clk),
    .rst         (rst),
    .temps_q     (temps_q),
    .thresh      (thresh),
    .cand_idx    (cand_idx),
    .min_dwell   (min_dwell),
    .pgood_delay (pgood_delay),
    .xfer_done   (xfer_done),
    .pwr_en      (core_pwr_en),
    .migrate_req (migrate_req),
    .target_idx  (target_idx),
    .active_idx  (active_idx)
  );
endmodule

// File: tb/test_thermal_migrator.sv
`timescale 1ns/1ps
module test_thermal_migrator;
  localparam int N  = 4;
  localparam int TW = 8;
  localparam int DW = 16;
  localparam int PW = 8;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [TW-1:0] t [N];
  logic [N*TW-1:0] core_temp;
  logic [TW-1:0] ambient_temp = '0;
  logic [TW-1:0] base_thresh = 8'd200;
  logic [DW-1:0] min_dwell = 16'd5;
  logic [PW-1:0] pgood_delay = 8'd3;
  logic          xfer_done = 1'b0;
  logic [N-1:0]  core_pwr_en;
  logic          migrate_req;
  logic [IW-1:0] target_idx;
  logic [IW-1:0] active_idx;

  int checks = 0;
  int errors = 0;
  int handovers = 0;
  bit finished = 1'b0;
  logic [IW-1:0] exp_q [$];

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) core_temp[i*TW +: TW] = t[i];
  end

  thermal_migrator #(
    .N_CORES(N), .TEMP_W(TW), .DWELL_W(DW), .PGOOD_W(PW), .AMB_SHIFT(2)
  ) i_thermal_migrator (
    .clk(clk), .rst(rst), .core_temp(core_temp), .ambient_temp(ambient_temp),
    .base_thresh(base_thresh), .min_dwell(min_dwell), .pgood_delay(pgood_delay),
    .xfer_done(xfer_done), .core_pwr_en(core_pwr_en), .migrate_req(migrate_req),
    .target_idx(target_idx), .active_idx(active_idx)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_target(input logic [IW-1:0] tgt);
    exp_q.push_back(tgt);
  endtask

  // Monitor: pops expected destinations and checks each handover
  initial begin : monitor
    logic [IW-1:0] cur_active;
    logic [IW-1:0] tgt;
    int cnt;
    cur_active = '0;
    @(negedge clk);
    while (rst) @(negedge clk);
    forever begin
      @(negedge clk);
      if ($countones(core_pwr_en) == 2) begin
        cnt = 0;
        while (!migrate_req) begin
          cnt++;
          @(negedge clk);
        end
        check(cnt == int'(pgood_delay) + 1, "R7 power-good wait", cnt, int'(pgood_delay) + 1);
        if (exp_q.size() == 0) begin
          check(1'b0, "R5 unexpected migration", int'(target_idx), -1);
          tgt = target_idx;
        end else begin
          tgt = exp_q.pop_front();
          check(target_idx == tgt, "R5 coolest gated core", int'(target_idx), int'(tgt));
        end
        check(core_pwr_en == ((N'(1) << cur_active) | (N'(1) << tgt)),
              "R7 overlap of old and new core", int'(core_pwr_en),
              int'((N'(1) << cur_active) | (N'(1) << tgt)));
        for (int k = 0; k < 3; k++) begin
          @(negedge clk);
          check(migrate_req == 1'b1, "R8 request held until done", int'(migrate_req), 1);
        end
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        check(migrate_req == 1'b0, "R8 request dropped after done", int'(migrate_req), 0);
        @(negedge clk);
        check(core_pwr_en == (N'(1) << tgt), "R9 old core gated", int'(core_pwr_en),
              int'(N'(1) << tgt));
        check(active_idx == tgt, "R9 active index updated", int'(active_idx), int'(tgt));
        cur_active = tgt;
        handovers++;
      end
    end
  end

  task automatic quiet_window(input int cycles, input string req);
    bit moved;
    moved = 1'b0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (migrate_req || $countones(core_pwr_en) != 1) moved = 1'b1;
    end
    check(!moved, req, int'(moved), 0);
    check(core_pwr_en == 4'b0001, req, int'(core_pwr_en), 1);
  endtask

  initial begin : main
    int cnt;
    for (int i = 0; i < N; i++) t[i] = 8'd100;
    ambient_temp = 8'd40;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    check(core_pwr_en == 4'b0001, "R1 reset power", int'(core_pwr_en), 1);
    check(migrate_req == 1'b0, "R1 reset request", int'(migrate_req), 0);
    check(active_idx == 0, "R1 reset active", int'(active_idx), 0);

    // R3: all cool, threshold 190 -> nothing happens
    quiet_window(30, "R3 below threshold");

    // R4: cool ambient, threshold 200, core0 at 199 -> nothing
    ambient_temp = 8'd0;
    t[0] = 8'd199;
    quiet_window(30, "R4 cool ambient raises limit");
    t[0] = 8'd180;
    quiet_window(10, "R3 below limit at 180 vs 200");

    // R3 inclusive compare: ambient 80 -> threshold 180 == core0 temp
    // R5 tie between core2 and core3 at 90 -> core 2
    t[1] = 8'd120; t[2] = 8'd90; t[3] = 8'd90;
    @(negedge clk);
    @(negedge clk);
    expect_target(2'd2);
    ambient_temp = 8'd80;
    wait (migrate_req == 1'b1);
    // prepare second migration: core2 becomes hot, tie core1/core3 -> core 1
    t[0] = 8'd150; t[1] = 8'd60; t[2] = 8'd250; t[3] = 8'd60;
    expect_target(2'd1);
    wait (handovers == 1);
    // R6 dwell: new migration begins exactly min_dwell+1 cycles later
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
    end while ($countones(core_pwr_en) != 2 && cnt < 100);
    check(cnt == int'(min_dwell) + 1, "R6 minimum dwell", cnt, int'(min_dwell) + 1);
    wait (handovers == 2);
    @(negedge clk);
    check(active_idx == 1, "R2 active after second handover", int'(active_idx), 1);

    // third migration with zero power-good wait; tie core0/core3 -> core 0
    pgood_delay = 8'd0;
    t[0] = 8'd70; t[2] = 8'd100; t[3] = 8'd70;
    @(negedge clk);
    @(negedge clk);
    expect_target(2'd0);
    t[1] = 8'd250;
    wait (handovers == 3);
    @(negedge clk);
    check($countones(core_pwr_en) == 1, "R2 single core at end", $countones(core_pwr_en), 1);
    check(exp_q.size() == 0, "R5 all expected migrations seen", exp_q.size(), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", handovers, 3);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule